// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block turns time-base event strobes into two registered PWM levels, `pwm_a` and `pwm_b`. Each clock it looks at four one-cycle strobes: counter reached zero, counter reached period, counter matched compare A while counting up, and counter matched compare B while counting up. For each output a 16-bit action word says what every event does to that output: nothing, drive low, drive high or toggle. When several strobes land in the same cycle, one of them is picked by a fixed priority.

A continuous software force can hold either output low or high no matter what the events ask for. Software writes the force value into a shadow register. A two-bit reload selector decides when the shadow value is copied into the active force register: on the zero event, on the period event, on either of them, or at once. Register writes come in through one word-wide port, and a two-bit address picks the target register.

Each output is a two-state machine with states `LVL_LOW` and `LVL_HIGH`. A force to low makes the transition to `LVL_LOW` and a force to high makes the transition to `LVL_HIGH`. With no force active, the chosen action decides the move: a low action goes to `LVL_LOW`, a high action goes to `LVL_HIGH`, a toggle goes to the other state, and no action stays in the current state. The reload selector is held in one of four named states: `RLD_ZERO`, `RLD_PERIOD`, `RLD_EITHER` and `RLD_NOW`. It changes only when software writes it. The force decoder maps a two-bit force field to one of three values: `FRC_OFF`, `FRC_LOW` or `FRC_HIGH`.

Top module: `pwm_action_qual`

## Requirements
- R1: An action code is two bits. 00 does nothing, 01 drives the output low, 10 drives it high, and 11 toggles it.
- R2: In each output's action word, the zero event uses bits [1:0], the period event [3:2], compare-A-up [5:4] and compare-B-up [9:8].
- R3: When strobes coincide, only those whose action code is not 00 take part. Among them compare B wins over compare A, compare A over period, and period over zero.
- R4: In the force word, bits [1:0] hold the force for output A and bits [3:2] the force for output B. 01 forces low, 10 forces high, and both 00 and 11 mean no force.
- R5: While an active force is low or high, the output stays at the forced level whatever events arrive.
- R6: The reload selector is bits [7:6] of the reload word. 00 copies shadow to active on the zero strobe, 01 on the period strobe, 10 on either strobe, and 11 on every clock. Without a reload point, the active force keeps its old value.
- R7: With reload 11, a force written on clock edge k sets the output from edge k+1. The output is unchanged right after edge k.
- R8: Reset drives both outputs low and clears every action, reload and force register to zero, so events then have no effect.
- R9: An output changes on the clock edge that samples the strobe, as a registered level.
- R10: Write address 0 selects the A action word, 1 the B action word, 2 the reload word and 3 the force word. A write changes only the register it selects.
- R11: Action words of zero/period high with own compare low give the normal waveform. Zero/period low with own compare high give the inverted waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_zero | input | 1 | Counter-equals-zero strobe |
| ev_period | input | 1 | Counter-equals-period strobe |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 A action, 1 B action, 2 reload, 3 force) |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Registered output A |
| pwm_b | output | 1 | Registered output B |

## Verification
The action path is driven in several ways:
- Single strobes under normal and inverted action words show that each field position and code is decoded correctly.
- Repeated toggle strobes show that the output inverts its own state rather than driving a fixed level.
- Coincident strobe pairs are chosen so that the winner and the loser ask for opposite levels. This makes the priority order visible, and a pair with one 00 field shows that a no-action code does not block a lower-priority event.
- The force sequences write a shadow value and then send a non-reload strobe, a reload strobe and an idle cycle in turn. Each reload mode then shows a different edge where the force takes hold or lets go.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10
    } frc_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic cmpb;
        logic cmpa;
        logic period;
        logic zero;
    } ev_t;

    localparam int FLD_ZERO_LSB = 0;
    localparam int FLD_PRD_LSB  = 2;
    localparam int FLD_CMPA_LSB = 4;
    localparam int FLD_CMPB_LSB = 8;
    localparam int RLD_SEL_LSB  = 6;
    localparam int FRC_FLD_W    = 2;

    function automatic frc_e decode_force(input logic [1:0] code);
        case (code)
            2'b01:   return FRC_LOW;
            2'b10:   return FRC_HIGH;
            default: return FRC_OFF;
        endcase
    endfunction

endpackage

// File: rtl/aq_force_ctrl.sv
module aq_force_ctrl
    import pwmaq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_OUT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  ev_t                           ev,
    input  logic                          wr_rld,
    input  logic                          wr_frc,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [FRC_FLD_W*NUM_OUT-1:0]  frc_act
);

    localparam int FRC_W = FRC_FLD_W * NUM_OUT;

    rld_e             rld_q;
    logic [FRC_W-1:0] shadow_q;
    logic [FRC_W-1:0] active_q;
    logic [FRC_W-1:0] shadow_nxt;
    logic             load;
    logic             unused_bits;

    assign unused_bits = ^{1'b0, wr_data};

    always_comb begin
        shadow_nxt = wr_frc ? wr_data[FRC_W-1:0] : shadow_q;
    end

    // reload point decided by the selector state
    always_comb begin
        load = 1'b0;
        unique case (rld_q)
            RLD_ZERO:   load = ev.zero;
            RLD_PERIOD: load = ev.period;
            RLD_EITHER: load = ev.zero | ev.period;
            RLD_NOW:    load = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q    <= RLD_ZERO;
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_rld) begin
                rld_q <= rld_e'(wr_data[RLD_SEL_LSB +: 2]);
            end
            shadow_q <= shadow_nxt;
            if (load) begin
                active_q <= shadow_nxt;
            end
        end
    end

    assign frc_act = active_q;

    // R6: without a reload strobe in zero mode the active force holds
    a_r6_hold_without_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_q == RLD_ZERO && !ev.zero) |=> $stable(active_q));

    // R7: immediate mode takes the written value on the write edge
    a_r7_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_q == RLD_NOW && wr_frc) |=> (active_q == $past(wr_data[FRC_W-1:0])));

endmodule

// File: rtl/aq_channel.sv
module aq_channel
    import pwmaq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_t               ev,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        frc_code,
    output logic              pwm
);

    logic [DATA_W-1:0] act_q;
    act_e              f_zero, f_prd, f_cmpa, f_cmpb, sel_act;
    frc_e              frc;
    lvl_e              state_q, state_nxt;
    logic              unused_bits;

    assign unused_bits = ^{1'b0, act_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (wr_act) begin
            act_q <= wr_data;
        end
    end

    assign f_zero = act_e'(act_q[FLD_ZERO_LSB +: 2]);
    assign f_prd  = act_e'(act_q[FLD_PRD_LSB  +: 2]);
    assign f_cmpa = act_e'(act_q[FLD_CMPA_LSB +: 2]);
    assign f_cmpb = act_e'(act_q[FLD_CMPB_LSB +: 2]);
    assign frc    = decode_force(frc_code);

    // later checks override earlier ones: zero < period < cmpA < cmpB
    always_comb begin
        sel_act = ACT_NONE;
        if (ev.zero   && f_zero != ACT_NONE) sel_act = f_zero;
        if (ev.period && f_prd  != ACT_NONE) sel_act = f_prd;
        if (ev.cmpa   && f_cmpa != ACT_NONE) sel_act = f_cmpa;
        if (ev.cmpb   && f_cmpb != ACT_NONE) sel_act = f_cmpb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (frc)
            FRC_LOW:  state_nxt = LVL_LOW;
            FRC_HIGH: state_nxt = LVL_HIGH;
            FRC_OFF: begin
                unique case (sel_act)
                    ACT_NONE:   state_nxt = state_q;
                    ACT_LOW:    state_nxt = LVL_LOW;
                    ACT_HIGH:   state_nxt = LVL_HIGH;
                    ACT_TOGGLE: state_nxt = (state_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
                endcase
            end
            default: state_nxt = state_q;
        endcase
    end

    always_comb begin
        pwm = (state_q == LVL_HIGH);
    end

    // R5: forced levels win over every event
    a_r5_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_code == 2'b01) |=> !pwm);
    a_r5_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_code == 2'b10) |=> pwm);

    // R9: with no strobe and no force the level is held
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0 && frc_code != 2'b01 && frc_code != 2'b10) |=> $stable(pwm));

    // R3: compare B with a low action decides when unforced
    a_r3_cmpb_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.cmpb && act_q[FLD_CMPB_LSB +: 2] == 2'b01 && frc_code != 2'b10) |=> !pwm);

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwmaq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_zero,
    input  logic              ev_period,
    input  logic              ev_cmpa_up,
    input  logic              ev_cmpb_up,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int          NUM_OUT  = 2;
    localparam logic [ADDR_W-1:0] ADDR_ACT0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_RLD  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_FRC  = ADDR_W'(3);

    ev_t                            ev;
    logic [FRC_FLD_W*NUM_OUT-1:0]   frc_act;
    logic [NUM_OUT-1:0]             pwm_vec;

    assign ev = '{cmpb: ev_cmpb_up, cmpa: ev_cmpa_up, period: ev_period, zero: ev_zero};

    aq_force_ctrl #(
        .DATA_W  (DATA_W),
        .NUM_OUT (NUM_OUT)
    ) u_force (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wr_rld  (wr_en && wr_addr == ADDR_RLD),
        .wr_frc  (wr_en && wr_addr == ADDR_FRC),
        .wr_data (wr_data),
        .frc_act (frc_act)
    );

    for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_ch
        aq_channel #(
            .DATA_W (DATA_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev),
            .wr_act   (wr_en && wr_addr == (ADDR_ACT0 + ADDR_W'(ch))),
            .wr_data  (wr_data),
            .frc_code (frc_act[FRC_FLD_W*ch +: FRC_FLD_W]),
            .pwm      (pwm_vec[ch])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

    // R8: outputs are low in the first cycle after reset
    a_r8_reset_low: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pwm_a && !pwm_b));

endmodule

// File: tb/tb_pwm_action_qual.sv
module tb_pwm_action_qual;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam bit [3:0] E_ZERO = 4'b0001, E_PRD = 4'b0010, E_CA = 4'b0100, E_CB = 4'b1000;

    always #4 clk = ~clk;

    pwm_action_qual dut (
        .clk(clk), .rst_n(rst_n),
        .ev_zero(ev_zero), .ev_period(ev_period),
        .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(input bit [3:0] e);
        @(negedge clk);
        {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = e;
        @(negedge clk);
        {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = 4'b0000;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R8 reset a", pwm_a, 1'b0);
        chk("R8 reset b", pwm_b, 1'b0);
        pulse(E_ZERO | E_PRD);
        chk("R8 cleared regs a", pwm_a, 1'b0);
        chk("R8 cleared regs b", pwm_b, 1'b0);
    endtask

    task automatic t_polarity();
        wr(2'd0, 16'h001A);   // A normal
        wr(2'd1, 16'h0205);   // B inverted
        pulse(E_ZERO);
        chk("R11 zero a high", pwm_a, 1'b1);
        chk("R11 zero b low", pwm_b, 1'b0);
        pulse(E_CA);
        chk("R2 cmpA a low", pwm_a, 1'b0);
        chk("R2 cmpA b unaffected", pwm_b, 1'b0);
        pulse(E_CB);
        chk("R2 cmpB a unaffected", pwm_a, 1'b0);
        chk("R11 cmpB b high", pwm_b, 1'b1);
        pulse(E_PRD);
        chk("R9 period a high", pwm_a, 1'b1);
        chk("R11 period b low", pwm_b, 1'b0);
    endtask

    task automatic t_toggle();
        wr(2'd0, 16'h0300);
        pulse(E_CB);
        chk("R1 toggle a first", pwm_a, 1'b0);
        pulse(E_CB);
        chk("R1 toggle a second", pwm_a, 1'b1);
    endtask

    task automatic t_priority();
        wr(2'd0, 16'h0126);   // zero hi, prd lo, cmpA hi, cmpB lo
        pulse(E_PRD);
        chk("R3 setup low", pwm_a, 1'b0);
        pulse(E_ZERO | E_PRD);
        chk("R3 period over zero", pwm_a, 1'b0);
        pulse(E_ZERO);
        chk("R3 zero alone", pwm_a, 1'b1);
        pulse(E_PRD | E_CA);
        chk("R3 cmpA over period", pwm_a, 1'b1);
        pulse(E_CA | E_CB);
        chk("R3 cmpB over cmpA", pwm_a, 1'b0);
        wr(2'd0, 16'h0026);   // cmpB no action
        pulse(E_ZERO | E_CB);
        chk("R3 none code does not block", pwm_a, 1'b1);
    endtask

    task automatic t_addr_iso();
        logic b_before;
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0000);
        b_before = pwm_b;
        pulse(E_PRD);
        chk("R10 A word kept", pwm_a, 1'b0);
        chk("R10 B word cleared", pwm_b, b_before);
    endtask

    task automatic t_force_now();
        wr(2'd0, 16'h001A);
        pulse(E_ZERO);
        chk("R11 setup high", pwm_a, 1'b1);
        wr(2'd2, 16'h00C0);
        wr(2'd3, 16'h0001);
        chk("R7 unchanged at write edge", pwm_a, 1'b1);
        idle(1);
        chk("R7 forced next edge", pwm_a, 1'b0);
        pulse(E_ZERO);
        chk("R5 force beats zero", pwm_a, 1'b0);
        wr(2'd3, 16'h0003);
        idle(1);
        pulse(E_ZERO);
        chk("R4 code 11 no force", pwm_a, 1'b1);
        wr(2'd3, 16'h0008);
        idle(1);
        chk("R4 force b high", pwm_b, 1'b1);
        chk("R4 a free", pwm_a, 1'b1);
        wr(2'd3, 16'h0006);
        idle(1);
        chk("R4 force a high", pwm_a, 1'b1);
        chk("R4 force b low", pwm_b, 1'b0);
        wr(2'd3, 16'h0000);
        idle(1);
    endtask

    task automatic t_reload();
        wr(2'd2, 16'h0000);   // zero reload
        wr(2'd3, 16'h0001);
        idle(3);
        chk("R6 zero mode waits", pwm_a, 1'b1);
        pulse(E_PRD);
        chk("R6 period no load", pwm_a, 1'b1);
        pulse(E_ZERO);
        chk("R6 load edge old force", pwm_a, 1'b1);
        idle(1);
        chk("R6 zero mode loaded", pwm_a, 1'b0);
        wr(2'd2, 16'h0040);   // period reload
        wr(2'd3, 16'h0000);
        pulse(E_ZERO);
        chk("R6 period mode ignores zero", pwm_a, 1'b0);
        pulse(E_PRD);
        chk("R6 period load edge", pwm_a, 1'b0);
        pulse(E_ZERO);
        chk("R6 period mode released", pwm_a, 1'b1);
        wr(2'd2, 16'h0080);   // either
        wr(2'd3, 16'h0001);
        pulse(E_PRD);
        chk("R6 either period edge", pwm_a, 1'b1);
        pulse(E_ZERO);
        chk("R6 either loaded on period", pwm_a, 1'b0);
        wr(2'd3, 16'h0000);
        pulse(E_ZERO);
        chk("R6 either zero load edge", pwm_a, 1'b0);
        pulse(E_ZERO);
        chk("R6 either released on zero", pwm_a, 1'b1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_polarity();
        t_toggle();
        t_priority();
        t_addr_iso();
        t_force_now();
        t_reload();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule